// File: doc/BRIEF.md
# ADC Offset and Gain Calibration Sequencer

This controller calibrates one analog-to-digital converter in a production fixture. It drives a 16-bit reference DAC one code at a time and reads back the converter's output codes. From these it measures the converter's offset and then its gain. The gain measurement already takes the measured offset into account. It then derives two fixed-point constants that firmware applies at run time: a gain factor and an additive correction. These are presented for one cycle on a parameter-write strobe so that an external store can capture them.

Each DAC step uses a handshake. The sequencer loads a code, waits for the fixture to acknowledge that the DAC output has settled, and then takes the first converter sample that arrives after that acknowledge. In single-ended mode the offset comes from a rising ramp that stops at the first output transition. In differential mode a single sample at zero input difference gives the offset. The gain ramp stops when the converter's top code appears. The midpoint of that top step is estimated from the width of the step below it, and an internal iterative divider forms the ratio. A ramp that hits DAC full scale, a missing step, or an out-of-range ratio ends the run with an error flag instead of a parameter write.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, done_o, err_o, param_we_o and dac_load_o are low and dac_code_o is zero.
- R2: Every DAC step raises dac_load_o for exactly one cycle with the new code on dac_code_o. The step's sample is the first cycle with adc_valid_i high that comes strictly after a cycle with dac_settled_i high; an adc_valid_i that arrives before the settle acknowledge is ignored.
- R3: The offset ramp and the gain ramp each start at DAC code 0. Each later load within a ramp is the previous code plus STEP = 2^STEP_LOG2. No ramp loads a code above 2^DAC_W-1.
- R4: In single-ended mode (diff_i=0, codes unsigned), A is the code sampled at DAC 0. B is the first code that differs from A, and P is the DAC code where B appears. The offset, counted in DAC units, is 64*B - 32 - P; one converter LSB is 2^(DAC_W-ADC_W) = 64 DAC counts.
- R5: In differential mode (diff_i=1, codes two's complement), the offset is 64 times the signed code sampled at DAC 0, with no ramp.
- R6: The gain ramp runs until the code equals the top code: 1023 in single-ended mode and 511 in differential mode. Let E be the DAC code where the top code first appears and F the DAC code where the previous code change occurred. The midpoint is M = E + floor((E-F)/2).
- R7: The gain factor is floor(M * 2^14 / (64*top - offset)), an unsigned quotient presented on factor_o (16 bits, 14 fraction bits).
- R8: The correction is 2^13 - floor(offset * factor / 64), presented as a signed 32-bit value on correction_o.
- R9: A successful run pulses param_we_o for exactly one cycle with valid factor_o and correction_o. done_o rises on the next cycle with err_o low, and done_o stays high until the next start_i.
- R10: If a ramp would step past DAC full scale before finding its transition or top code, or if the top code appears without an earlier code change in the gain ramp, the run ends with done_o and err_o high and no param_we_o pulse.
- R11: If the gain denominator is not positive, or the quotient reaches 2.0 (2^15), the run ends with done_o and err_o high and no param_we_o pulse.
- R12: start_i clears done_o and err_o on the next cycle and begins a run. diff_i is sampled only in that start cycle; later changes have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration run |
| diff_i | input | 1 | Mode: 0 single-ended, 1 differential |
| dac_code_o | output | 16 | Code for the reference DAC |
| dac_load_o | output | 1 | One-cycle strobe: new DAC code |
| dac_settled_i | input | 1 | Fixture acknowledge: DAC output settled |
| adc_valid_i | input | 1 | Converter sample valid |
| adc_code_i | input | 10 | Converter output code |
| factor_o | output | 16 | Gain factor, 14 fraction bits |
| correction_o | output | 32 | Signed correction constant |
| param_we_o | output | 1 | One-cycle write strobe for the constants |
| done_o | output | 1 | Run finished (level) |
| err_o | output | 1 | Run failed (valid with done_o) |

## Verification
Corrupt ramp or offset state shows up within one run as a wrong factor_o or correction_o on the single write strobe. A stepping fault shows earlier, as a dac_code_o load that is not zero and not the previous code plus STEP. If the sequencer takes a sample before the settle acknowledge, a stale code injected ahead of the acknowledge shifts the measured offset, and the constants for that run change. A wrong termination rule turns into a missing write or an unexpected err_o when done_o rises. Mode latching is exposed by toggling diff_i immediately after start_i, which changes the results when the mode is not held.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OFS,
    ST_GAIN,
    ST_PREP,
    ST_DIV,
    ST_CORR,
    ST_WRITE
  } cal_state_e;

  typedef enum logic [1:0] {
    SP_IDLE,
    SP_SETTLE,
    SP_SAMPLE
  } step_state_e;

endpackage

// File: rtl/adc_cal_step.sv
module adc_cal_step
  import adc_cal_pkg::*;
#(
  parameter int DAC_W = 16,
  parameter int ADC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DAC_W-1:0] code_i,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             dac_load_o,
  input  logic             dac_settled_i,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_code_i,
  output logic             smp_valid_o,
  output logic [ADC_W-1:0] smp_code_o
);

  step_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SP_IDLE;
      dac_code_o  <= '0;
      dac_load_o  <= 1'b0;
      smp_valid_o <= 1'b0;
      smp_code_o  <= '0;
    end else begin
      dac_load_o  <= 1'b0;
      smp_valid_o <= 1'b0;
      case (st_q)
        SP_IDLE: if (go_i) begin
          dac_code_o <= code_i;
          dac_load_o <= 1'b1;
          st_q       <= SP_SETTLE;
        end
        // valid before the settle acknowledge is stale and dropped
        SP_SETTLE: if (dac_settled_i) st_q <= SP_SAMPLE;
        SP_SAMPLE: if (adc_valid_i) begin
          smp_valid_o <= 1'b1;
          smp_code_o  <= adc_code_i;
          st_q        <= SP_IDLE;
        end
        default: st_q <= SP_IDLE;
      endcase
    end
  end

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |=> !dac_load_o); // R2
  AST_SAMPLE_NOT_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> !dac_load_o); // R2
  AST_CODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != SP_IDLE) |=> $stable(dac_code_o)); // R2

endmodule

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
  parameter int NUM_W = 31,
  parameter int DEN_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, quo_o[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        rem_q  <= '0;
        den_q  <= den_i;
        quo_o  <= num_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quo_o <= {quo_o[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DIV_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q)); // R7
  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

endmodule

// File: rtl/adc_cal_corr.sv
module adc_cal_corr #(
  parameter int OFS_W  = 18,
  parameter int FAC_W  = 16,
  parameter int COR_W  = 32,
  parameter int SHIFT  = 6,
  parameter int FRAC_W = 14
) (
  input  logic signed [OFS_W-1:0] ofs_i,
  input  logic        [FAC_W-1:0] fac_i,
  output logic        [COR_W-1:0] corr_o
);

  localparam int PROD_W = OFS_W + FAC_W;

  logic signed [FAC_W-1:0]  fac_s;
  logic signed [PROD_W-1:0] prod, scaled, full;

  assign fac_s  = $signed(fac_i);
  assign prod   = ofs_i * fac_s;
  assign scaled = prod >>> SHIFT;
  assign full   = $signed(PROD_W'(1) << (FRAC_W - 1)) - scaled;

  generate
    if (PROD_W >= COR_W) begin : g_trunc
      assign corr_o = full[COR_W-1:0];
    end else begin : g_ext
      assign corr_o = {{(COR_W-PROD_W){full[PROD_W-1]}}, full};
    end
  endgenerate

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int DAC_W     = 16,
  parameter int ADC_W     = 10,
  parameter int FRAC_W    = 14,
  parameter int STEP_LOG2 = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  diff_i,
  output logic [DAC_W-1:0]      dac_code_o,
  output logic                  dac_load_o,
  input  logic                  dac_settled_i,
  input  logic                  adc_valid_i,
  input  logic [ADC_W-1:0]      adc_code_i,
  output logic [FRAC_W+1:0]     factor_o,
  output logic [2*FRAC_W+3:0]   correction_o,
  output logic                  param_we_o,
  output logic                  done_o,
  output logic                  err_o
);

  localparam int LSB_SH = DAC_W - ADC_W;
  localparam int OFS_W  = DAC_W + 2;
  localparam int MID_W  = DAC_W + 1;
  localparam int NUM_W  = MID_W + FRAC_W;
  localparam int FAC_W  = FRAC_W + 2;
  localparam int COR_W  = 2 * FAC_W;
  localparam int HALF_L = 1 << (LSB_SH - 1);
  localparam logic [DAC_W:0] STEP = (DAC_W+1)'(1) << STEP_LOG2;

  cal_state_e st_q;
  logic                    diff_q, first_q, seen_q, step_go_q, div_go_q;
  logic [DAC_W-1:0]        dac_pos_q, prev_q;
  logic [ADC_W-1:0]        last_q;
  logic signed [OFS_W-1:0] ofs_q;
  logic [MID_W-1:0]        mid_q;

  logic                    smp_valid, div_done;
  logic [ADC_W-1:0]        smp_code;
  logic [NUM_W-1:0]        quo;
  logic [COR_W-1:0]        corr_w;

  // ramp stepping
  logic [DAC_W:0]          nxt;
  logic                    ramp_end;
  assign nxt      = {1'b0, dac_pos_q} + STEP;
  assign ramp_end = nxt[DAC_W];

  // offset candidates
  logic signed [OFS_W-1:0] ofs_se, ofs_d;
  assign ofs_se = $signed({2'b00, smp_code, {LSB_SH{1'b0}}})
                - $signed(OFS_W'(HALF_L))
                - $signed({2'b00, dac_pos_q});
  assign ofs_d  = {{2{smp_code[ADC_W-1]}}, smp_code, {LSB_SH{1'b0}}};

  // top code and its DAC-count equivalent
  logic [ADC_W-1:0] top_code;
  logic [OFS_W-1:0] top_cnt;
  logic             top_hit;
  assign top_code = diff_q ? {1'b0, {(ADC_W-1){1'b1}}} : {ADC_W{1'b1}};
  assign top_cnt  = {2'b00, top_code, {LSB_SH{1'b0}}};
  assign top_hit  = smp_code == top_code;

  logic [DAC_W-1:0] step_len;
  logic [MID_W-1:0] mid_w;
  assign step_len = dac_pos_q - prev_q;
  assign mid_w    = {1'b0, dac_pos_q} + MID_W'(step_len >> 1);

  logic signed [OFS_W:0] den_s;
  logic                  den_bad, quo_big;
  assign den_s   = $signed({1'b0, top_cnt}) - $signed({ofs_q[OFS_W-1], ofs_q});
  assign den_bad = den_s <= 0;
  assign quo_big = |quo[NUM_W-1:FAC_W-1];

  adc_cal_step #(.DAC_W(DAC_W), .ADC_W(ADC_W)) u_step (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (step_go_q),
    .code_i       (dac_pos_q),
    .dac_code_o   (dac_code_o),
    .dac_load_o   (dac_load_o),
    .dac_settled_i(dac_settled_i),
    .adc_valid_i  (adc_valid_i),
    .adc_code_i   (adc_code_i),
    .smp_valid_o  (smp_valid),
    .smp_code_o   (smp_code)
  );

  adc_cal_div #(.NUM_W(NUM_W), .DEN_W(OFS_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go_q),
    .num_i  ({mid_q, {FRAC_W{1'b0}}}),
    .den_i  (den_s[OFS_W-1:0]),
    .done_o (div_done),
    .quo_o  (quo)
  );

  adc_cal_corr #(.OFS_W(OFS_W), .FAC_W(FAC_W), .COR_W(COR_W),
                 .SHIFT(LSB_SH), .FRAC_W(FRAC_W)) u_corr (
    .ofs_i (ofs_q),
    .fac_i (factor_o),
    .corr_o(corr_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      diff_q       <= 1'b0;
      first_q      <= 1'b0;
      seen_q       <= 1'b0;
      step_go_q    <= 1'b0;
      div_go_q     <= 1'b0;
      dac_pos_q    <= '0;
      prev_q       <= '0;
      last_q       <= '0;
      ofs_q        <= '0;
      mid_q        <= '0;
      factor_o     <= '0;
      correction_o <= '0;
      param_we_o   <= 1'b0;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      step_go_q <= 1'b0;
      div_go_q  <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          diff_q    <= diff_i;
          done_o    <= 1'b0;
          err_o     <= 1'b0;
          dac_pos_q <= '0;
          first_q   <= 1'b1;
          step_go_q <= 1'b1;
          st_q      <= ST_OFS;
        end
        ST_OFS: if (smp_valid) begin
          if (diff_q || (!first_q && smp_code != last_q)) begin
            ofs_q     <= diff_q ? ofs_d : ofs_se;
            dac_pos_q <= '0;
            first_q   <= 1'b1;
            seen_q    <= 1'b0;
            step_go_q <= 1'b1;
            st_q      <= ST_GAIN;
          end else begin
            if (first_q) last_q <= smp_code;
            first_q <= 1'b0;
            if (ramp_end) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              dac_pos_q <= nxt[DAC_W-1:0];
              step_go_q <= 1'b1;
            end
          end
        end
        ST_GAIN: if (smp_valid) begin
          first_q <= 1'b0;
          if (top_hit) begin
            // a top step with no step below it gives no width estimate
            if (!seen_q || first_q) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              mid_q <= mid_w;
              st_q  <= ST_PREP;
            end
          end else begin
            if (first_q) begin
              last_q <= smp_code;
            end else if (smp_code != last_q) begin
              last_q <= smp_code;
              prev_q <= dac_pos_q;
              seen_q <= 1'b1;
            end
            if (ramp_end) begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              dac_pos_q <= nxt[DAC_W-1:0];
              step_go_q <= 1'b1;
            end
          end
        end
        ST_PREP: begin
          if (den_bad) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            div_go_q <= 1'b1;
            st_q     <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          if (quo_big) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            factor_o <= quo[FAC_W-1:0];
            st_q     <= ST_CORR;
          end
        end
        ST_CORR: begin
          correction_o <= corr_w;
          param_we_o   <= 1'b1;
          st_q         <= ST_WRITE;
        end
        ST_WRITE: begin
          param_we_o <= 1'b0;
          done_o     <= 1'b1;
          st_q       <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_WE_THEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    param_we_o |=> (done_o && !err_o)); // R9
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    param_we_o |=> !param_we_o); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_FACTOR_BELOW_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    param_we_o |-> !factor_o[FAC_W-1]); // R11
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R12
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && !err_o)); // R12
  AST_NO_LOAD_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dac_load_o); // R3

endmodule

// File: tb/sim_adc_cal_seq.sv
module sim_adc_cal_seq;

  localparam int SL   = 5;
  localparam int STEP = 1 << SL;
  localparam int NV   = 6;
  localparam int VEC_DIFF [NV] = '{0, 0, 0, 0, 1, 1};
  localparam int VEC_OFF  [NV] = '{0, 100, -90, 40, -150, 70};
  localparam int VEC_GN   [NV] = '{1024, 1024, 1000, 1050, 1024, 980};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, diff = 1'b0;
  logic [15:0] dac_code;
  logic        dac_load;
  logic        settled = 1'b0, valid = 1'b0;
  logic [9:0]  code = '0;
  logic [15:0] factor;
  logic [31:0] corr;
  logic        we, done, err;

  always #2 clk = ~clk;

  adc_cal_seq #(.STEP_LOG2(SL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .diff_i(diff),
    .dac_code_o(dac_code), .dac_load_o(dac_load), .dac_settled_i(settled),
    .adc_valid_i(valid), .adc_code_i(code), .factor_o(factor),
    .correction_o(corr), .param_we_o(we), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_diff = 0, m_off = 0, m_gn = 1024, m_stale = 0;
  int we_cnt = 0, late_done = 0, seq_bad = 0, prev_code = 0;
  longint cap_fac = 0, cap_cor = 0;
  int exp_err = 0;
  longint exp_fac = 0, exp_cor = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint fdiv(longint a, longint b);
    longint q = a / b;
    if ((a % b != 0) && ((a < 0) != (b < 0))) q--;
    return q;
  endfunction

  function automatic int adc_model(int dac);
    longint v = (longint'(dac) * m_gn) / 1024 + m_off;
    longint q = fdiv(v + 32, 64);
    if (m_diff != 0) begin
      if (q < -512) q = -512;
      if (q > 511) q = 511;
    end else begin
      if (q < 0) q = 0;
      if (q > 1023) q = 1023;
    end
    return int'(q);
  endfunction

  // expected constants from the measurement rules R4..R11
  task automatic expect_run();
    longint ofs = 0, mid = 0, den, q;
    int pos, a, c, last, prev, seen, top;
    exp_err = 0; exp_fac = 0; exp_cor = 0;
    top = (m_diff != 0) ? 511 : 1023;
    if (m_diff != 0) ofs = 64 * adc_model(0);
    else begin
      a = adc_model(0); pos = 0;
      forever begin
        if (pos + STEP > 65535) begin exp_err = 1; return; end
        pos += STEP; c = adc_model(pos);
        if (c != a) begin ofs = 64 * c - 32 - pos; break; end
      end
    end
    pos = 0; last = adc_model(0); seen = 0; prev = 0;
    if (last == top) begin exp_err = 1; return; end
    forever begin
      if (pos + STEP > 65535) begin exp_err = 1; return; end
      pos += STEP; c = adc_model(pos);
      if (c == top) begin
        if (seen == 0) begin exp_err = 1; return; end
        mid = pos + (pos - prev) / 2; break;
      end else if (c != last) begin prev = pos; seen = 1; last = c; end
    end
    den = 64 * top - ofs;
    if (den <= 0) begin exp_err = 1; return; end
    q = (mid <<< 14) / den;
    if (q >= 32768) begin exp_err = 1; return; end
    exp_fac = q;
    exp_cor = 8192 - ((ofs * q) >>> 6);
  endtask

  // fixture: settle acknowledge then one sample; optional stale valid first
  initial forever begin
    @(negedge clk);
    if (dac_load) begin
      automatic int c = int'(dac_code);
      if (m_stale != 0) begin valid = 1'b1; code = 10'h2AA; end
      @(negedge clk); valid = 1'b0; settled = 1'b1;
      @(negedge clk); settled = 1'b0; valid = 1'b1; code = 10'(adc_model(c));
      @(negedge clk); valid = 1'b0;
    end
  end

  // monitors
  logic prev_we = 1'b0;
  initial forever begin
    @(negedge clk);
    cyc++;
    if (prev_we && !done) late_done++;
    prev_we = we;
    if (we) begin we_cnt++; cap_fac = longint'(factor); cap_cor = longint'($signed(corr)); end
    if (dac_load) begin
      if (int'(dac_code) != 0 && int'(dac_code) != prev_code + STEP) seq_bad++;
      prev_code = int'(dac_code);
    end
  end

  initial begin
    wait (cyc >= 195000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 195000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic run(input int d, input int off, input int gn, input int stale,
                     input string tag);
    int t0;
    m_diff = d; m_off = off; m_gn = gn; m_stale = stale;
    expect_run();
    we_cnt = 0; late_done = 0; seq_bad = 0;
    diff = d[0];
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; diff = ~d[0];
    chk(!done && !err, "R12", {tag, " start clears done"}, longint'(done), 0);
    t0 = cyc;
    while (!done && cyc - t0 < 40000) @(negedge clk);
    chk(done, "R9", {tag, " done"}, longint'(done), 1);
    chk(int'(err) == exp_err, exp_err ? "R10" : "R9", {tag, " err"}, longint'(err), exp_err);
    chk(we_cnt == (exp_err ? 0 : 1), "R9", {tag, " write count"}, we_cnt, exp_err ? 0 : 1);
    chk(late_done == 0, "R9", {tag, " done after write"}, late_done, 0);
    chk(seq_bad == 0, "R3", {tag, " ramp step"}, seq_bad, 0);
    if (exp_err == 0) begin
      chk(cap_fac == exp_fac, "R7", {tag, " factor"}, cap_fac, exp_fac);
      chk(cap_cor == exp_cor, d ? "R5 R8" : "R4 R8", {tag, " correction"}, cap_cor, exp_cor);
    end
    repeat (3) @(negedge clk);
    chk(done && int'(err) == exp_err, "R12", {tag, " done held"}, longint'(done), 1);
    m_stale = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !err && !we, "R1", "reset flags", {done, err, we}, 0);
    chk(!dac_load && dac_code == 0, "R1", "reset dac", longint'(dac_code), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !dac_load, "R1", "idle after reset", longint'(done), 0);
    // main table: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++)
      run(VEC_DIFF[i], VEC_OFF[i], VEC_GN[i], 0, $sformatf("vec%0d", i));
    // R2: stale valid ahead of settle acknowledge must be ignored
    run(0, 100, 1024, 1, "stale");
    // R10: gain ramp never reaches top code
    run(0, 0, 900, 0, "gain_ramp_end");
    chk(err, "R10", "gain ramp error", longint'(err), 1);
    // R10: offset ramp never sees a transition
    run(0, 0, 0, 0, "ofs_ramp_end");
    chk(err, "R10", "offset ramp error", longint'(err), 1);
    // R11: ratio reaches 2.0
    run(1, 16000, 500, 0, "factor_two");
    chk(err, "R11", "factor overflow error", longint'(err), 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule